// File: doc/BRIEF.md
# Serial Result Readout Master

This block sends a 16-bit conversion result to a host over a three-wire serial link that it drives itself. It generates the serial clock, a frame-sync strobe and the data line. The conversion engine sits outside it and supplies three things: a start pulse, a done pulse and the data word. The block keeps the busy flag that the host watches.

A mode input selects when a result goes out. In read-during-convert mode, each accepted start pulse launches a frame that carries the word latched at the previous done pulse, while the new conversion runs. In read-after-convert mode, the done pulse launches a frame that carries the fresh word at once, and busy stays high until the last bit has gone out. Only the read-after-convert mode applies a two-bit divide setting, which stretches the serial clock. Separate inputs invert the clock and the sync polarity. An output-enable flag stands in for the tri-state condition: it is true only while chip-select and read are both low.

Top module: `ser_readout`

## Requirements
- R1: While reset is high and in the first cycle after it, busy is 0. The sync output sits at its deasserted level, which equals `sync_inv`. The serial clock sits at its idle level, which equals `sclk_inv`.
- R2: A frame carries exactly 16 bits, MSB first. Each bit occupies 2·H cycles, where H is the half-period in clock cycles. `sdo` changes only at the start of a bit and is held for the whole bit. Outside a frame `sdo` is 0.
- R3: Sync is asserted for exactly 32·H cycles, beginning in the cycle after the launching pulse is sampled. Asserted means 1 when `sync_inv`=0 and 0 when `sync_inv`=1.
- R4: With `sclk_inv`=0 the clock is low for the first H cycles of each bit and high for the last H cycles, and it is low when idle. `sclk_inv`=1 inverts every one of these levels.
- R5: With `rd_mode`=0 (read after convert), a sampled `conv_done` latches `conv_data` and launches a frame that carries that word. Busy stays 1 through the whole frame and falls in the same cycle that sync deasserts.
- R6: With `rd_mode`=1 (read during convert), an accepted `conv_start` raises busy and launches a frame at the same edge. The frame carries the word latched at the previous `conv_done`, which is 0 after reset. Busy falls in the cycle after `conv_done` is sampled.
- R7: H equals HALF_BASE shifted left by `div_sel` (codes 0..3 give 1x, 2x, 4x, 8x) when `rd_mode`=0. H equals HALF_BASE for any `div_sel` when `rd_mode`=1.
- R8: `out_en` is 1 exactly when `cs_n`=0 and `rd_n`=0, in the same cycle.
- R9: A `conv_start` that arrives while busy is 1 is ignored. Busy stays 1 and the frame in flight is unchanged.
- R10: A `conv_done` that arrives during a frame does not change the bits of that frame. The next frame in read-during-convert mode carries the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Conversion start pulse |
| conv_done | input | 1 | Conversion complete pulse, qualifies conv_data |
| conv_data | input | 16 | Conversion result word |
| rd_mode | input | 1 | 0 = read after convert, 1 = read during convert |
| div_sel | input | 2 | Serial clock divide code (read-after mode only) |
| sclk_inv | input | 1 | Invert serial clock |
| sync_inv | input | 1 | Sync active-low when 1 |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read, active low |
| busy | output | 1 | Conversion/transfer in progress |
| sclk | output | 1 | Generated serial clock |
| sdo | output | 1 | Serial data |
| sync | output | 1 | Frame sync |
| out_en | output | 1 | Serial outputs driven (else high impedance) |

## Verification
Two functions can fall into the same cycle. A new result can arrive while a frame is still shifting the old one, and a new start pulse can arrive while a read-after-convert frame still holds busy high. The bench injects `conv_done` or `conv_start` at a fixed bit position inside a frame that it is checking cycle by cycle. It judges the result on the waveform of that same frame, on the busy level before and after the injection, and on the content of the following frame.

// File: rtl/ser_readout_pkg.sv
package ser_readout_pkg;

    typedef enum logic {
        RD_AFTER  = 1'b0,
        RD_DURING = 1'b1
    } rd_mode_e;

    typedef enum logic [1:0] {
        DIV_X1 = 2'd0,
        DIV_X2 = 2'd1,
        DIV_X4 = 2'd2,
        DIV_X8 = 2'd3
    } sclk_div_e;

    // raw (un-inverted) line state produced by the shifter
    typedef struct packed {
        logic active;
        logic sclk_raw;
        logic sdo;
    } ser_line_t;

    // half-period length in clock cycles for a frame
    function automatic int unsigned half_len(int unsigned base, rd_mode_e m, sclk_div_e d);
        if (m == RD_DURING) return base;
        return base << d;
    endfunction

endpackage

// File: rtl/ser_halfclk.sv
module ser_halfclk #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == per_q - CNT_W'(1));
    assign tick = run & last;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= CNT_W'(1);
            cnt_q <= '0;
        end else if (load) begin
            per_q <= period;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R7: counter never runs past the latched half-period
    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < per_q));

    // R7: the latched half-period stays fixed while a frame runs
    a_r7_period_held: assert property (@(posedge clk) disable iff (rst)
        (run && !load && $past(run)) |-> $stable(per_q));

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
    import ser_readout_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] word,
    input  logic          tick,
    output ser_line_t     line,
    output logic          frame_end
);
    localparam int BIT_W = $clog2(DW);

    logic [DW-1:0]    shreg_q;
    logic [BIT_W-1:0] bit_q;
    logic             phase_q;
    logic             active_q;

    assign frame_end     = active_q & tick & phase_q & (bit_q == BIT_W'(DW - 1));
    assign line.active   = active_q;
    assign line.sclk_raw = active_q & phase_q;
    assign line.sdo      = active_q & shreg_q[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q  <= '0;
            bit_q    <= '0;
            phase_q  <= 1'b0;
            active_q <= 1'b0;
        end else if (load) begin
            shreg_q  <= word;
            bit_q    <= '0;
            phase_q  <= 1'b0;
            active_q <= 1'b1;
        end else if (active_q && tick) begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                shreg_q <= {shreg_q[DW-2:0], 1'b0};
                bit_q   <= bit_q + BIT_W'(1);
                if (bit_q == BIT_W'(DW - 1)) active_q <= 1'b0;
            end
        end
    end

    // R2: data holds across the rising edge of its clock pulse
    a_r2_sdo_stable_mid_bit: assert property (@(posedge clk) disable iff (rst)
        (active_q && tick && !phase_q) |=> $stable(line.sdo));

    // R3: a frame closes right after its last bit
    a_r3_frame_closes: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !line.active);

    // R2: every frame begins at bit zero in the low phase
    a_r2_frame_starts_low: assert property (@(posedge clk) disable iff (rst)
        $rose(active_q) |-> (bit_q == '0 && !phase_q));

endmodule

// File: rtl/ser_readout.sv
module ser_readout
    import ser_readout_pkg::*;
#(
    parameter int DW        = 16,
    parameter int HALF_BASE = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_start,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_data,
    input  logic          rd_mode,
    input  logic [1:0]    div_sel,
    input  logic          sclk_inv,
    input  logic          sync_inv,
    input  logic          cs_n,
    input  logic          rd_n,
    output logic          busy,
    output logic          sclk,
    output logic          sdo,
    output logic          sync,
    output logic          out_en
);
    localparam int CNT_W = $clog2(HALF_BASE * 8) + 1;

    rd_mode_e         mode;
    sclk_div_e        div;
    logic [DW-1:0]    result_q;
    logic             busy_q;
    logic             start_acc;
    logic             frame_go;
    logic             frame_end;
    logic             tick;
    logic [DW-1:0]    frame_word;
    logic [CNT_W-1:0] period;
    ser_line_t        line;

    assign mode       = rd_mode_e'(rd_mode);
    assign div        = sclk_div_e'(div_sel);
    assign start_acc  = conv_start & ~busy_q;
    assign frame_go   = ~line.active &
                        ((mode == RD_DURING) ? start_acc : conv_done);
    assign frame_word = (mode == RD_DURING) ? result_q : conv_data;
    assign period     = CNT_W'(half_len(HALF_BASE, mode, div));

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            busy_q   <= 1'b0;
        end else begin
            if (conv_done) result_q <= conv_data;
            if (start_acc)
                busy_q <= 1'b1;
            else if (mode == RD_DURING && conv_done)
                busy_q <= 1'b0;
            else if (mode == RD_AFTER && frame_end)
                busy_q <= 1'b0;
        end
    end

    ser_halfclk #(.CNT_W(CNT_W)) i_halfclk (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_go),
        .run    (line.active),
        .period (period),
        .tick   (tick)
    );

    ser_shifter #(.DW(DW)) i_shifter (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_go),
        .word      (frame_word),
        .tick      (tick),
        .line      (line),
        .frame_end (frame_end)
    );

    assign busy   = busy_q;
    assign sclk   = line.sclk_raw ^ sclk_inv;
    assign sdo    = line.sdo;
    assign sync   = line.active ^ sync_inv;
    assign out_en = ~cs_n & ~rd_n;

    // R1: busy comes out of reset low
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> !busy);

    // R5: in read-after mode a running frame keeps busy high
    a_r5_busy_covers_frame: assert property (@(posedge clk) disable iff (rst)
        (mode == RD_AFTER && line.active) |-> busy);

    // R9: a start pulse while busy leaves busy set
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && conv_start && !(mode == RD_DURING && conv_done)) |=> busy);

    // R6: in read-during mode completion clears busy next cycle
    a_r6_done_clears: assert property (@(posedge clk) disable iff (rst)
        (mode == RD_DURING && conv_done && !conv_start) |=> !busy);

endmodule

// File: tb/test_ser_readout.sv
`timescale 1ns/1ps
module test_ser_readout;
    localparam int DW = 16;
    localparam int HB = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_start = 1'b0;
    logic          conv_done  = 1'b0;
    logic [DW-1:0] conv_data  = '0;
    logic          rd_mode    = 1'b0;
    logic [1:0]    div_sel    = 2'd0;
    logic          sclk_inv   = 1'b0;
    logic          sync_inv   = 1'b0;
    logic          cs_n       = 1'b1;
    logic          rd_n       = 1'b1;
    logic          busy, sclk, sdo, sync, out_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ser_readout #(.DW(DW), .HALF_BASE(HB)) i_ser_readout (
        .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data), .rd_mode(rd_mode), .div_sel(div_sel),
        .sclk_inv(sclk_inv), .sync_inv(sync_inv), .cs_n(cs_n), .rd_n(rd_n),
        .busy(busy), .sclk(sclk), .sdo(sdo), .sync(sync), .out_en(out_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at the negedge of frame cycle 0. inj: 0 none, 1 done, 2 start at cycle inj_k.
    task automatic frame_check(input logic [DW-1:0] word, input int h, input bit after,
                               input int inj, input int inj_k, input logic [DW-1:0] inj_word,
                               input string tag);
        int bad = 0;
        int bbad = 0;
        for (int k = 0; k < 32 * h; k++) begin
            logic exp_sclk, exp_sdo, exp_sync, exp_busy;
            exp_sclk = logic'(((k / h) % 2) != 0) ^ sclk_inv;
            exp_sdo  = word[DW - 1 - k / (2 * h)];
            exp_sync = 1'b1 ^ sync_inv;
            exp_busy = (!after && inj == 1 && k > inj_k) ? 1'b0 : 1'b1;
            if (sclk !== exp_sclk || sdo !== exp_sdo || sync !== exp_sync) bad++;
            if (busy !== exp_busy) bbad++;
            if (inj != 0 && k == inj_k) begin
                if (inj == 1) begin conv_done = 1'b1; conv_data = inj_word; end
                else conv_start = 1'b1;
            end
            @(negedge clk);
            conv_done  = 1'b0;
            conv_start = 1'b0;
        end
        // R2 R3 R4 R10: waveform of whole frame
        check(bad == 0, {tag, " R2/R3/R4 frame waveform mismatched cycles"}, bad, 0);
        check(bbad == 0, {tag, " busy during frame (R5/R6/R9) bad cycles"}, bbad, 0);
        // R3: sync deasserts exactly after 32*H cycles, clock idles, sdo 0
        check(sync === sync_inv && sclk === sclk_inv && sdo === 1'b0,
              {tag, " R3 frame end idle levels"}, {sync, sclk, sdo}, {sync_inv, sclk_inv, 1'b0});
        if (after) check(busy === 1'b0, {tag, " R5 busy falls with sync"}, busy, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] last_word = '0;
        // R1: reset levels for both polarity settings
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R1 busy in reset", busy, 0);
        check(sync === 1'b0, "R1 sync deasserted (non-inv)", sync, 0);
        check(sclk === 1'b0, "R1 sclk idle (non-inv)", sclk, 0);
        sclk_inv = 1'b1; sync_inv = 1'b1;
        #1;
        check(sync === 1'b1, "R1 sync deasserted (inv)", sync, 1);
        check(sclk === 1'b1, "R1 sclk idle (inv)", sclk, 1);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && sync === 1'b1, "R1 first cycle after reset", {busy, sync}, 1);

        // R8: output enable truth table
        for (int c = 0; c < 4; c++) begin
            cs_n = c[0]; rd_n = c[1];
            #1;
            check(out_en === (c == 0), "R8 out_en", out_en, (c == 0));
        end
        cs_n = 1'b0; rd_n = 1'b0;

        // R5 R7: read-after sweep over divide codes and both polarities
        rd_mode = 1'b0;
        for (int i = 0; i < 16; i++) begin
            logic [DW-1:0] w;
            w = (i == 0) ? 16'hFFFF : (i == 15) ? 16'h0001 : (16'hA5C3 ^ DW'(i * 4999));
            div_sel  = 2'(i / 4);
            sclk_inv = i[0];
            sync_inv = i[1];
            @(negedge clk);
            conv_start = 1'b1;
            @(negedge clk);
            conv_start = 1'b0;
            check(busy === 1'b1, "R5 busy rises on start", busy, 1);
            repeat (3) @(negedge clk);
            check(sync === sync_inv, "R5 no frame before done", sync, sync_inv);
            conv_done = 1'b1; conv_data = w;
            @(negedge clk);
            conv_done = 1'b0;
            // R7: H = HB << div_sel
            frame_check(w, HB << (i / 4), 1'b1, 0, 0, '0, $sformatf("R7 after div=%0d", i / 4));
            last_word = w;
        end

        // R9: start pulse mid-frame in read-after mode is ignored
        div_sel = 2'd1; sclk_inv = 1'b0; sync_inv = 1'b0;
        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        conv_done = 1'b1; conv_data = 16'h3C5A;
        @(negedge clk);
        conv_done = 1'b0;
        frame_check(16'h3C5A, HB << 1, 1'b1, 2, 37, '0, "R9 start during frame");
        last_word = 16'h3C5A;

        // R6 R7 R10: read-during mode, div_sel must not matter
        rd_mode = 1'b1; div_sel = 2'd3; sclk_inv = 1'b1; sync_inv = 1'b0;
        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        // R6: frame carries previous result; R10: done at cycle 21 must not alter it
        frame_check(last_word, HB, 1'b0, 1, 21, 16'h9E17, "R6 during frame prev word");
        check(busy === 1'b0, "R6 busy low after done", busy, 0);

        sclk_inv = 1'b0; sync_inv = 1'b1;
        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        // R10: next frame carries the word delivered mid-frame
        frame_check(16'h9E17, HB, 1'b0, 1, 63, 16'h0000, "R10 next frame new word");
        check(busy === 1'b0, "R6 busy cleared by done", busy, 0);

        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        frame_check(16'h0000, HB, 1'b0, 0, 0, '0, "R2 during zero word");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule